// File: doc/BRIEF.md
# Interrupt Request Latch with Edge/Level Capture

This block keeps the pending-request vector of an eight-input interrupt controller, together with the in-service vector and the priority rotation offset that acknowledge cycles change. Each raw request line first crosses a two-flop synchronizer. A per-input trigger-mode bit then sets how the line is captured. A level input mirrors the synchronized line directly. An edge input latches a request on a low-to-high transition and keeps it until an acknowledge takes it.

The priority resolver and the command decoder sit outside this block. The resolver returns the winning input number on an acknowledge strobe, together with the auto-EOI and rotate-on-auto-EOI flags. Clears of in-service bits arrive already decoded as a mask. A write port loads the trigger-mode register. A per-instance parameter masks that write, so inputs that must stay edge-triggered cannot be switched to level.

Top module: `irq_req_latch`

## Requirements
- R1: After reset the request vector, the in-service vector and the rotation offset are all zero, and every input is edge-triggered (trigger-mode bit 0).
- R2: A change on a raw input reaches the request vector at the third rising clock edge after it is applied: two synchronizer edges, then the latch edge.
- R3: For an input whose trigger-mode bit is 1 (level), the request bit equals the synchronized input level, and an acknowledge of that input leaves the bit set.
- R4: For an input whose trigger-mode bit is 0 (edge), the request bit is set when the synchronized input is high and was low on the previous sample. A falling input leaves a pending request set.
- R5: An acknowledge of an edge-triggered input clears its request bit at the next clock edge.
- R6: An acknowledge with auto-EOI low sets the in-service bit of the acknowledged input and leaves the rotation offset unchanged.
- R7: An acknowledge with auto-EOI high does not set an in-service bit. If rotate-on-auto-EOI is also high, the rotation offset becomes (input number + 1) mod 8. Otherwise the offset is unchanged.
- R8: A trigger-mode write stores the written value ANDed with the writable-bit parameter mask. Bits outside the mask stay 0 (edge).
- R9: When an acknowledge and a new rising edge on the same edge-triggered input fall in the same cycle, the request bit stays set.
- R10: In-service bits named in the clear mask are zero after the next clock edge, unless the same edge sets that bit through an acknowledge, in which case the bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw | input | 8 | Raw asynchronous interrupt lines |
| ack_valid | input | 1 | Acknowledge strobe, one cycle |
| ack_id | input | 3 | Number of the acknowledged input |
| auto_eoi | input | 1 | Auto end-of-interrupt mode flag |
| rot_on_aeoi | input | 1 | Rotate priority on auto end-of-interrupt |
| mode_we | input | 1 | Trigger-mode register write enable |
| mode_wdata | input | 8 | Trigger-mode write data, 1 = level, 0 = edge |
| isr_clr | input | 8 | Mask of in-service bits to clear |
| req_vec | output | 8 | Pending request vector |
| isr_vec | output | 8 | In-service vector |
| rot_ofs | output | 3 | Priority rotation offset |

## Verification
The assertions assume that ack_valid is a single-cycle strobe and that ack_id always names an existing input. The stimulus holds each raw line steady for at least three cycles, so the synchronizer never sees a glitch shorter than its depth. Strobes are driven on the falling edge for one cycle only. The sweeps cover every input in both trigger modes and every acknowledge number under each auto-EOI and rotate combination. Each change of raw level is given the full three-edge latency before its result is sampled.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_e;

    // next index after id, wrapping at count n
    function automatic int unsigned wrap_next(input int unsigned id, input int unsigned n);
        return (id + 1 >= n) ? 0 : id + 1;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.chain[STAGES-1];

    generate
        if (STAGES > 1) begin : g_chk
            AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.chain[1] == $past(st_q.chain[0]));  // R2
        end
    endgenerate
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank
    import irq_latch_pkg::*;
#(
    parameter int          N     = 8,
    parameter logic [N-1:0] WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  logic [N-1:0] ack_oh,
    input  logic         mode_we,
    input  logic [N-1:0] mode_wdata,
    output logic [N-1:0] req_o
);
    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] last;
        logic [N-1:0] mode;
    } bank_t;

    bank_t st_q, st_d;
    logic [N-1:0] edge_keep;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N; i++) begin
            if (trig_e'(st_q.mode[i]) == TRIG_LEVEL) begin
                st_d.req[i] = lvl_i[i];
            end else begin
                // a fresh edge outranks the acknowledge clear
                st_d.req[i] = (st_q.req[i] & ~ack_oh[i]) | (lvl_i[i] & ~st_q.last[i]);
            end
            st_d.last[i] = lvl_i[i];
        end
        if (mode_we) st_d.mode = mode_wdata & WMASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o     = st_q.req;
    assign edge_keep = st_q.req & ~st_q.mode & ~ack_oh;

    AST_LEVEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.req ^ $past(lvl_i)) & $past(st_q.mode)) == '0);  // R3
    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(edge_keep) & ~st_q.req) == '0);  // R4
    AST_EDGE_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ack_oh & ~st_q.mode & ~(lvl_i & ~st_q.last)) & st_q.req) == '0);  // R5
    AST_MODE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode & ~WMASK) == '0);  // R8
endmodule

// File: rtl/irq_isr_ctrl.sv
module irq_isr_ctrl
    import irq_latch_pkg::*;
#(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_id,
    input  logic [N-1:0]  ack_oh,
    input  logic          auto_eoi,
    input  logic          rot_on_aeoi,
    input  logic [N-1:0]  isr_clr,
    output logic [N-1:0]  isr_o,
    output logic [IW-1:0] rot_o
);
    typedef struct packed {
        logic [N-1:0]  isr;
        logic [IW-1:0] rot;
    } isr_t;

    isr_t st_q, st_d;
    logic [N-1:0] set_oh;

    always_comb begin
        set_oh = auto_eoi ? '0 : ack_oh;
        st_d   = st_q;
        st_d.isr = (st_q.isr & ~isr_clr) | set_oh;
        if (ack_valid && auto_eoi && rot_on_aeoi) begin
            st_d.rot = IW'(wrap_next(int'(ack_id), N));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign isr_o = st_q.isr;
    assign rot_o = st_q.rot;

    AST_ISR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !auto_eoi) |=> st_q.isr[$past(ack_id)]);  // R6
    AST_AEOI_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && auto_eoi && !st_q.isr[ack_id]) |=> !st_q.isr[$past(ack_id)]);  // R7
    AST_ROT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack_valid && auto_eoi && rot_on_aeoi) |=> $stable(st_q.rot));  // R7
    AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(isr_clr & ~set_oh) & st_q.isr) == '0);  // R10
    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_oh));  // R6
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
    parameter int           N            = 8,
    parameter int           SYNC_STAGES  = 2,
    parameter logic [N-1:0] MODE_WR_MASK = '1,
    localparam int          IW           = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_raw,
    input  logic          ack_valid,
    input  logic [IW-1:0] ack_id,
    input  logic          auto_eoi,
    input  logic          rot_on_aeoi,
    input  logic          mode_we,
    input  logic [N-1:0]  mode_wdata,
    input  logic [N-1:0]  isr_clr,
    output logic [N-1:0]  req_vec,
    output logic [N-1:0]  isr_vec,
    output logic [IW-1:0] rot_ofs
);
    logic [N-1:0] lvl_sync;
    logic [N-1:0] ack_oh;

    always_comb begin
        ack_oh = '0;
        if (ack_valid) ack_oh[ack_id] = 1'b1;
    end

    irq_sync #(.W(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_raw),
        .sync_o  (lvl_sync)
    );

    irq_req_bank #(.N(N), .WMASK(MODE_WR_MASK)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (lvl_sync),
        .ack_oh     (ack_oh),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .req_o      (req_vec)
    );

    irq_isr_ctrl #(.N(N)) u_isr (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_valid   (ack_valid),
        .ack_id      (ack_id),
        .ack_oh      (ack_oh),
        .auto_eoi    (auto_eoi),
        .rot_on_aeoi (rot_on_aeoi),
        .isr_clr     (isr_clr),
        .isr_o       (isr_vec),
        .rot_o       (rot_ofs)
    );

    AST_ACK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (int'(ack_id) < N));  // R6
endmodule

// File: tb/irq_req_latch_bench.sv
module irq_req_latch_bench;
    localparam int       CLK_PERIOD = 10;
    localparam logic [7:0] WMASK    = 8'hDE;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_raw = '0;
    logic       ack_valid = 1'b0;
    logic [2:0] ack_id = '0;
    logic       auto_eoi = 1'b0;
    logic       rot_on_aeoi = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] isr_clr = '0;
    logic [7:0] req_vec, isr_vec;
    logic [2:0] rot_ofs;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_req_latch #(.N(8), .SYNC_STAGES(2), .MODE_WR_MASK(WMASK)) u_irq_req_latch (
        .clk, .rst_n, .irq_raw, .ack_valid, .ack_id, .auto_eoi, .rot_on_aeoi,
        .mode_we, .mode_wdata, .isr_clr, .req_vec, .isr_vec, .rot_ofs
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_ack(input int id, input logic aeoi, input logic rot);
        ack_valid = 1'b1; ack_id = 3'(id); auto_eoi = aeoi; rot_on_aeoi = rot;
        cyc(1);
        ack_valid = 1'b0; auto_eoi = 1'b0; rot_on_aeoi = 1'b0;
    endtask

    task automatic wr_mode(input logic [7:0] v);
        mode_we = 1'b1; mode_wdata = v;
        cyc(1);
        mode_we = 1'b0;
    endtask

    initial begin
        logic [7:0] exp_req, exp_isr;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 req", req_vec, 8'h00);
        chk("R1 isr", isr_vec, 8'h00);
        chk("R1 rot", {5'd0, rot_ofs}, 8'h00);

        // edge capture on every input, latency check
        exp_req = '0;
        for (int i = 0; i < 8; i++) begin
            irq_raw[i] = 1'b1;
            cyc(2);
            chk("R2 not yet", req_vec, exp_req);
            cyc(1);
            exp_req[i] = 1'b1;
            chk("R4 edge set", req_vec, exp_req);
        end
        irq_raw = '0;
        cyc(3);
        chk("R4 held after fall", req_vec, 8'hFF);

        // acknowledge sweep, no auto-EOI
        exp_isr = '0;
        for (int i = 0; i < 8; i++) begin
            do_ack(i, 1'b0, 1'b0);
            exp_req[i] = 1'b0;
            exp_isr[i] = 1'b1;
            chk("R5 edge ack clears", req_vec, exp_req);
            chk("R6 isr set", isr_vec, exp_isr);
            chk("R6 rot kept", {5'd0, rot_ofs}, 8'h00);
        end
        isr_clr = 8'h0F; cyc(1); isr_clr = '0;
        chk("R10 partial clear", isr_vec, 8'hF0);
        isr_clr = 8'hFF; cyc(1); isr_clr = '0;
        chk("R10 full clear", isr_vec, 8'h00);

        // masked trigger-mode write
        wr_mode(8'hFF);
        irq_raw = 8'hFF; cyc(3);
        chk("R8 all high", req_vec, 8'hFF);
        irq_raw = 8'h00; cyc(3);
        chk("R3/R8 level drop, edge held", req_vec, ~WMASK);
        irq_raw = 8'hFF; cyc(3);
        chk("R3 level high again", req_vec, 8'hFF);

        // auto-EOI with rotation sweep
        exp_req = 8'hFF;
        for (int i = 0; i < 8; i++) begin
            do_ack(i, 1'b1, 1'b1);
            if (!WMASK[i]) exp_req[i] = 1'b0;
            chk("R3/R5 ack per mode", req_vec, exp_req);
            chk("R7 no isr", isr_vec, 8'h00);
            chk("R7 rot", {5'd0, rot_ofs}, 8'((i + 1) % 8));
        end
        do_ack(4, 1'b1, 1'b0);
        chk("R7 rot unchanged", {5'd0, rot_ofs}, 8'h00);
        do_ack(3, 1'b1, 1'b1);
        do_ack(6, 1'b1, 1'b0);
        chk("R7 rot kept at 4", {5'd0, rot_ofs}, 8'h04);
        irq_raw = 8'h00; cyc(3);
        chk("R3 level follows low", req_vec, 8'h00);

        // acknowledge and new edge together
        wr_mode(8'h00);
        irq_raw[0] = 1'b1;
        cyc(2);
        do_ack(0, 1'b0, 1'b0);
        chk("R9 edge wins", req_vec, 8'h01);
        do_ack(0, 1'b0, 1'b0);
        chk("R5 later ack clears", req_vec, 8'h00);
        irq_raw = '0; cyc(3);

        // set beats clear on the same bit
        isr_clr = 8'h08;
        do_ack(3, 1'b0, 1'b0);
        isr_clr = '0;
        chk("R10 set wins", isr_vec, 8'h09);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule